// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 device from power-on to a ready state with no software involvement. After the block leaves reset it first lets the memory out of reset with on-die termination enabled and clock enable held low. After a long settling wait it raises clock enable. It then programs the four mode registers in a fixed order, writing the mode register that holds the DLL reset bit twice. It waits for the DLL to lock and runs a long ZQ calibration. When that calibration wait has run out it raises a completion flag, and the regular controller then takes over the command bus.

Every interval is a parameter counted in clock cycles, so a simulation can use short waits and silicon can use the real ones. Between commands the block drives a deselect on the command slot, with all active-low strobes high. The command slot is combinational from registered state, so each command occupies exactly one cycle.

Top module: `ddr3_init_seq`

## Requirements
- R1: While rst_ni is low, mem_rst_n_o, cke_o, odt_o and init_done_o are 0 and cs_n_o, ras_n_o, cas_n_o and we_n_o are all 1. This takes effect immediately, because the reset is asynchronous.
- R2: From the first clock edge after reset release, for T_PWR_CYC cycles, mem_rst_n_o is 1, odt_o is 1 and cke_o is 0, and no command is issued.
- R3: cke_o rises T_PWR_CYC+1 edges after reset release and stays high until reset. No command (cs_n_o low) is ever driven while cke_o is low.
- R4: Mode register set commands have cs_n, ras_n, cas_n and we_n all 0. They are issued in the order MR2, MR3, MR1, MR0, MR0, with ba_o equal to the register number (2, 3, 1, 0, 0). The first one appears T_XPR_CYC cycles after cke_o rises.
- R5: The addresses of those five commands are 0x200, 0x000, 0x006, 0x320 (DLL reset set) and 0x220 (DLL reset cleared).
- R6: Each command lasts one cycle. Consecutive mode register commands are 1+T_MRD_CYC cycles apart, and the slot is deselected in between.
- R7: The ZQ long calibration has cs_n=0, we_n=0, ras_n=1, cas_n=1, addr 0x400 (bit 10 set) and ba 0. It is issued 1+T_DLLK_CYC cycles after the second MR0 command.
- R8: init_done_o rises 1+T_ZQ_CYC cycles after the ZQ command and stays high until reset. While it is high the slot stays deselected.
- R9: An asserted reset in the middle of the sequence returns the outputs to the R1 state. The next release restarts the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_rst_n_o | output | 1 | Memory reset, active low |
| cke_o | output | 1 | Memory clock enable |
| odt_o | output | 1 | On-die termination enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address |
| init_done_o | output | 1 | Initialization complete, sticky |

## Verification
A wrong step index shows up at the next command as the wrong bank or address, or as a strobe pattern out of order, one cycle after the index goes wrong. A wrong wait counter moves every later command off its expected cycle, so the timestamp attached to each expected command catches a one-cycle slip at the first command after the faulty wait. A stuck state appears either as a command that was never seen or as init_done_o failing to rise on its computed edge.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [2:0] {
    ST_RESET, ST_PWR, ST_CKE, ST_CMD, ST_GAP, ST_DLLK, ST_ZQW, ST_DONE
  } state_e;

  typedef enum logic [1:0] {CMD_NOP, CMD_MRS, CMD_ZQCL} cmd_e;

  typedef struct packed {
    cmd_e        kind;
    logic [2:0]  ba;
    logic [15:0] addr;
  } slot_t;

  localparam logic [2:0] STEP_LAST_MRS = 3'd4;
  localparam logic [2:0] STEP_ZQ       = 3'd5;

  localparam slot_t SLOT_NOP = '{kind: CMD_NOP, ba: 3'd0, addr: 16'h0000};

  // step order is behaviour: MR2, MR3, MR1, MR0 (DLL reset), MR0, ZQ long
  function automatic slot_t step_slot(input logic [2:0] idx);
    slot_t s;
    case (idx)
      3'd0:    s = '{kind: CMD_MRS,  ba: 3'd2, addr: 16'h0200};
      3'd1:    s = '{kind: CMD_MRS,  ba: 3'd3, addr: 16'h0000};
      3'd2:    s = '{kind: CMD_MRS,  ba: 3'd1, addr: 16'h0006};
      3'd3:    s = '{kind: CMD_MRS,  ba: 3'd0, addr: 16'h0320};
      3'd4:    s = '{kind: CMD_MRS,  ba: 3'd0, addr: 16'h0220};
      3'd5:    s = '{kind: CMD_ZQCL, ba: 3'd0, addr: 16'h0400};
      default: s = SLOT_NOP;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/init_wait_cnt.sv
module init_wait_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o); // R6

endmodule

// File: rtl/init_cmd_enc.sv
module init_cmd_enc
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BA_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_t             slot_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    cs_n_o  = 1'b1;
    ras_n_o = 1'b1;
    cas_n_o = 1'b1;
    we_n_o  = 1'b1;
    ba_o    = '0;
    addr_o  = '0;
    case (slot_i.kind)
      CMD_MRS: begin
        cs_n_o = 1'b0; ras_n_o = 1'b0; cas_n_o = 1'b0; we_n_o = 1'b0;
        ba_o   = slot_i.ba[BA_W-1:0];
        addr_o = slot_i.addr[ADDR_W-1:0];
      end
      CMD_ZQCL: begin
        cs_n_o = 1'b0; we_n_o = 1'b0;
        ba_o   = slot_i.ba[BA_W-1:0];
        addr_o = slot_i.addr[ADDR_W-1:0];
      end
      default: ;
    endcase
  end

  AST_ZQ_A10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && ras_n_o && cas_n_o && !we_n_o) |-> (addr_o[10] && ba_o == '0)); // R7

  AST_MRS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o) |-> (ba_o < BA_W'(4))); // R4

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned BA_W       = 3,
  parameter int unsigned T_PWR_CYC  = 50000,
  parameter int unsigned T_XPR_CYC  = 27,
  parameter int unsigned T_MRD_CYC  = 4,
  parameter int unsigned T_DLLK_CYC = 600,
  parameter int unsigned T_ZQ_CYC   = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rst_n_o,
  output logic              cke_o,
  output logic              odt_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int unsigned MAX_A   = (T_PWR_CYC > T_XPR_CYC) ? T_PWR_CYC : T_XPR_CYC;
  localparam int unsigned MAX_B   = (T_DLLK_CYC > T_ZQ_CYC) ? T_DLLK_CYC : T_ZQ_CYC;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_W   = (MAX_C > T_MRD_CYC) ? MAX_C : T_MRD_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_W + 1);

  state_e           state_q, state_d;
  logic [2:0]       step_q, step_d;
  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  slot_t            slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_RESET: state_d = ST_PWR;
      ST_PWR:   if (cnt_zero) state_d = ST_CKE;
      ST_CKE:   if (cnt_zero) state_d = ST_CMD;
      ST_CMD: begin
        step_d = step_q + 3'd1;
        if (step_q == STEP_LAST_MRS)  state_d = ST_DLLK;
        else if (step_q == STEP_ZQ)   state_d = ST_ZQW;
        else                          state_d = ST_GAP;
      end
      ST_GAP, ST_DLLK: if (cnt_zero) state_d = ST_CMD;
      ST_ZQW:   if (cnt_zero) state_d = ST_DONE;
      default:  state_d = ST_DONE;
    endcase
  end

  // load on entry so a wait state lasts exactly its parameter
  assign cnt_load = (state_d != state_q);

  always_comb begin
    case (state_d)
      ST_PWR:  cnt_val = CNT_W'(T_PWR_CYC - 1);
      ST_CKE:  cnt_val = CNT_W'(T_XPR_CYC - 1);
      ST_GAP:  cnt_val = CNT_W'(T_MRD_CYC - 1);
      ST_DLLK: cnt_val = CNT_W'(T_DLLK_CYC - 1);
      ST_ZQW:  cnt_val = CNT_W'(T_ZQ_CYC - 1);
      default: cnt_val = '0;
    endcase
  end

  init_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  assign slot = (state_q == ST_CMD) ? step_slot(step_q) : SLOT_NOP;

  init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slot),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  assign mem_rst_n_o = (state_q != ST_RESET);
  assign odt_o       = (state_q != ST_RESET);
  assign cke_o       = (state_q != ST_RESET) && (state_q != ST_PWR);
  assign init_done_o = (state_q == ST_DONE);

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> cke_o); // R3

  AST_CKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o); // R3

  AST_CKE_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |-> (mem_rst_n_o && odt_o)); // R2

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |=> cs_n_o); // R6

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R8

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> cs_n_o); // R8

endmodule

// File: tb/ddr3_init_seq_test.sv
`timescale 1ns/1ps
module ddr3_init_seq_test;
  localparam int ADDR_W = 14;
  localparam int BA_W   = 3;
  localparam int T_PWR  = 20;
  localparam int T_XPR  = 5;
  localparam int T_MRD  = 4;
  localparam int T_DLLK = 30;
  localparam int T_ZQ   = 25;
  localparam int K0     = 1 + T_PWR + T_XPR;
  localparam int K_MR0B = K0 + 4 * (1 + T_MRD);
  localparam int K_ZQ   = K_MR0B + 1 + T_DLLK;
  localparam int K_DONE = K_ZQ + 1 + T_ZQ;

  typedef struct packed {
    int          cyc;
    logic [3:0]  strb;  // cs_n, ras_n, cas_n, we_n
    logic [2:0]  ba;
    logic [13:0] addr;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mem_rst_n_o, cke_o, odt_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, init_done_o;
  logic [BA_W-1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  ddr3_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .T_PWR_CYC(T_PWR), .T_XPR_CYC(T_XPR),
    .T_MRD_CYC(T_MRD), .T_DLLK_CYC(T_DLLK), .T_ZQ_CYC(T_ZQ)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_rst_n_o(mem_rst_n_o), .cke_o(cke_o), .odt_o(odt_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .init_done_o(init_done_o));

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cyc %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int c, input logic [3:0] s, input logic [2:0] b, input logic [13:0] a);
    q.push_back('{cyc: c, strb: s, ba: b, addr: a});
  endtask

  // R4 R5 R6 R7: full expected command stream
  task automatic push_all();
    push(K0,             4'b0000, 3'd2, 14'h200);
    push(K0 + 1*(1+T_MRD), 4'b0000, 3'd3, 14'h000);
    push(K0 + 2*(1+T_MRD), 4'b0000, 3'd1, 14'h006);
    push(K0 + 3*(1+T_MRD), 4'b0000, 3'd0, 14'h320);
    push(K_MR0B,         4'b0000, 3'd0, 14'h220);
    push(K_ZQ,           4'b0110, 3'd0, 14'h400);
  endtask

  task automatic wait_cyc(input int n);
    do @(negedge clk_i); while (cyc != n);
  endtask

  task automatic check_reset_state(input string req);
    chk({mem_rst_n_o, cke_o, odt_o, init_done_o} == 4'b0000, req,
        {mem_rst_n_o, cke_o, odt_o, init_done_o}, 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b1111, req,
        {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'hf);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished && !cs_n_o) begin
      if (q.size() == 0) begin
        chk(0, "R6 unexpected cmd", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'hf);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc, "R6 R7 cmd cycle", cyc, e.cyc);
        chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == e.strb, "R4 R7 strobes",
            {cs_n_o, ras_n_o, cas_n_o, we_n_o}, e.strb);
        chk(ba_o == e.ba, "R4 bank", ba_o, e.ba);
        chk(addr_o == e.addr, "R5 R7 addr", addr_o, e.addr);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset_state("R1");
    push_all();
    rst_ni = 1'b1;
    wait_cyc(2);
    chk(mem_rst_n_o && odt_o && !cke_o, "R2", {mem_rst_n_o, odt_o, cke_o}, 3'b110);
    wait_cyc(T_PWR);
    chk(!cke_o && cs_n_o, "R2 end", {cke_o, cs_n_o}, 2'b01);
    wait_cyc(T_PWR + 1);
    chk(cke_o, "R3", cke_o, 1);
    wait_cyc(K_DONE - 1);
    chk(!init_done_o, "R8 early", init_done_o, 0);
    wait_cyc(K_DONE);
    chk(init_done_o, "R8 rise", init_done_o, 1);
    wait_cyc(K_DONE + 20);
    chk(init_done_o && cs_n_o && cke_o, "R8 sticky", {init_done_o, cs_n_o, cke_o}, 3'b111);
    chk(q.size() == 0, "R4 all cmds seen", q.size(), 0);

    // R9: reset in the middle, then restart
    rst_ni = 1'b0;
    #1;
    check_reset_state("R1 R9");
    @(negedge clk_i);
    q.delete();
    push(K0, 4'b0000, 3'd2, 14'h200);
    push(K0 + 1 + T_MRD, 4'b0000, 3'd3, 14'h000);
    rst_ni = 1'b1;
    wait_cyc(K0 + 1 + T_MRD + 2);
    chk(q.size() == 0, "R9 partial", q.size(), 0);
    rst_ni = 1'b0;
    #1;
    check_reset_state("R9 mid");
    @(negedge clk_i);
    push_all();
    rst_ni = 1'b1;
    wait_cyc(T_PWR);
    chk(!cke_o && mem_rst_n_o, "R9 restart", {cke_o, mem_rst_n_o}, 2'b01);
    wait_cyc(K_DONE);
    chk(init_done_o, "R9 done", init_done_o, 1);
    chk(q.size() == 0, "R9 all cmds", q.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule